// File: doc/BRIEF.md
# External Interrupt Pending-Flag Detector

This block turns active-low external interrupt pins into pending flags for a processor core. Each line runs its pin through a synchronizer. It then keeps one pending bit, and that bit works in one of two ways.

- **Edge mode:** the bit latches on a falling edge of the pin. It stays set until the core acknowledges the interrupt or software writes to it.
- **Level mode:** the bit is the inverse of the synchronized pin, and writes from software are ignored.

The synchronized pin is also brought out so that a timer gate can use the same clean copy.

The number of lines is a parameter and defaults to two. Bit i of every vector port belongs to line i. Prioritisation, masking and vector generation belong to the interrupt controller that reads the pending bits.

Top module: `extint_detect`

## Requirements
- R1: `ext_sync[i]` equals `ext_n[i]` delayed by two rising clock edges, and it is 1 while reset is asserted.
- R2: After reset, with the pins held high, `pend` is 0 and stays 0. The synchronizer and the edge history start at 1, so releasing reset creates no false edge.
- R3: With the mode bit at 1 (edge mode), a high-to-low change of `ext_n[i]` sets `pend[i]` at the third rising edge after the change. A pin that stays low does not set the bit again once it is cleared.
- R4: In edge mode, a high `irq_ack[i]` clears `pend[i]` at the next rising edge.
- R5: In edge mode, a high `sw_wr[i]` loads `sw_wdata[i]` into `pend[i]` at the next rising edge. Writing 0 clears the bit, and writing 1 sets it as a test interrupt. A write takes priority over an acknowledge in the same cycle.
- R6: In edge mode, a detected falling edge sets `pend[i]` even when an acknowledge or a write of 0 arrives in the same cycle, so a new event is never lost.
- R7: With the mode bit at 0 (level mode), `pend[i]` is 1 exactly when the synchronized pin was 0 one cycle earlier. It follows the pin with three edges of latency.
- R8: In level mode, `sw_wr` and `irq_ack` have no effect on `pend`.
- R9: `sense_sel[i]` is registered (reset value 0, level mode) and governs the flag update from the following cycle on. After a switch to level mode, `pend[i]` takes the pin state two edges after the mode bit is driven.
- R10: Lines are independent: activity on line j never changes `pend[i]` for i different from j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | N_LINES | Raw active-low interrupt pins |
| sense_sel | input | N_LINES | Mode per line: 1 = falling edge, 0 = low level |
| sw_wr | input | N_LINES | Software write strobe to the pending bit |
| sw_wdata | input | N_LINES | Value written by software |
| irq_ack | input | N_LINES | Core acknowledge (vectoring) strobe |
| pend | output | N_LINES | Pending flags |
| ext_sync | output | N_LINES | Synchronized pin copy for timer gating |

## Verification
Assertions inside the flag logic check the following on every cycle:
- in level mode, the flag tracks the inverted synchronized pin;
- in edge mode, a detected edge always leaves the flag set;
- an acknowledge without an edge or a write clears the flag;
- with no event, the flag holds.

Only the bench scenarios can show the following:
- the end-to-end latency from pin to flag;
- the absence of a false edge after reset;
- that the edge is not re-armed while the pin stays low;
- the one-cycle delay of a mode change;
- that neighbouring lines stay isolated.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  // shift toward the MSB; the MSB is the synchronized output
  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_in};
  end

  // preset to 1 so an idle (high) pin looks settled out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/extint_fall.sv
module extint_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic fall
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  // high in one cycle, low in the next
  assign fall = prev_q & ~lvl_in;
endmodule

// File: rtl/extint_flag.sv
module extint_flag
  import extint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e sense,
  input  logic   lvl_in,
  input  logic   fall,
  input  logic   wr_en,
  input  logic   wr_data,
  input  logic   ack,
  output logic   pend
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    if (sense == SENSE_LEVEL) begin
      pend_en = 1'b1;
      pend_d  = ~lvl_in;
    end else if (fall) begin
      // a fresh edge wins over acknowledge and writes
      pend_en = 1'b1;
      pend_d  = 1'b1;
    end else if (wr_en) begin
      pend_en = 1'b1;
      pend_d  = wr_data;
    end else if (ack) begin
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  assert_level_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LEVEL) |=> (pend == !$past(lvl_in)));

  assert_edge_not_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_EDGE && fall) |=> pend);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_EDGE && !fall && !wr_en && ack) |=> !pend);

  assert_sw_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_EDGE && !fall && wr_en) |=> (pend == $past(wr_data)));

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_EDGE && !fall && !wr_en && !ack) |=> $stable(pend));
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int unsigned N_LINES     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] ext_n,
  input  logic [N_LINES-1:0] sense_sel,
  input  logic [N_LINES-1:0] sw_wr,
  input  logic [N_LINES-1:0] sw_wdata,
  input  logic [N_LINES-1:0] irq_ack,
  output logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] ext_sync
);
  localparam int unsigned STG = (SYNC_STAGES < MIN_SYNC_STAGES) ?
                                MIN_SYNC_STAGES : SYNC_STAGES;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    sense_e mode_q;
    sense_e mode_d;
    logic   lvl;
    logic   fall;

    always_comb begin
      mode_d = sense_e'(sense_sel[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= SENSE_LEVEL;
      else        mode_q <= mode_d;
    end

    extint_sync #(.STAGES(STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (ext_n[i]),
      .q_out (lvl)
    );

    extint_fall u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (lvl),
      .fall   (fall)
    );

    extint_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .sense   (mode_q),
      .lvl_in  (lvl),
      .fall    (fall),
      .wr_en   (sw_wr[i]),
      .wr_data (sw_wdata[i]),
      .ack     (irq_ack[i]),
      .pend    (pend[i])
    );

    assign ext_sync[i] = lvl;
  end
endmodule

// File: tb/extint_detect_bench.sv
`timescale 1ns/1ps
module extint_detect_bench;
  localparam int N = 2;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] ext_n, sense_sel, sw_wr, sw_wdata, irq_ack, pend, ext_sync;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  extint_detect #(.N_LINES(N)) u_extint_detect (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .sense_sel(sense_sel),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .irq_ack(irq_ack),
    .pend(pend), .ext_sync(ext_sync)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ext_n = '1; sense_sel = '0; sw_wr = '0; sw_wdata = '0; irq_ack = '0;
    tick(2);
    chk(ext_sync[0], 1'b1, "R1", "sync preset in reset");
    chk(pend[0], 1'b0, "R2", "pend in reset");
    rst_n = 1'b1;
    sense_sel = '1;
    tick(5);
    chk(pend[0], 1'b0, "R2", "no false edge line0");
    chk(pend[1], 1'b0, "R2", "no false edge line1");
  endtask

  task automatic t_edge_set_ack;
    ext_n[0] = 1'b0;
    tick(1); chk(ext_sync[0], 1'b1, "R1", "sync after 1 edge");
    tick(1); chk(ext_sync[0], 1'b0, "R1", "sync after 2 edges");
    chk(pend[0], 1'b0, "R3", "pend before 3rd edge");
    tick(1); chk(pend[0], 1'b1, "R3", "pend after 3rd edge");
    chk(pend[1], 1'b0, "R10", "other line untouched");
    irq_ack[0] = 1'b1; tick(1); irq_ack[0] = 1'b0;
    chk(pend[0], 1'b0, "R4", "ack clears");
    tick(4); chk(pend[0], 1'b0, "R3", "low pin does not re-set");
  endtask

  task automatic t_sw_write;
    sw_wr[0] = 1'b1; sw_wdata[0] = 1'b1; tick(1);
    chk(pend[0], 1'b1, "R5", "write 1 sets");
    sw_wdata[0] = 1'b0; irq_ack[0] = 1'b0; tick(1);
    chk(pend[0], 1'b0, "R5", "write 0 clears");
    sw_wdata[0] = 1'b1; irq_ack[0] = 1'b1; tick(1);
    chk(pend[0], 1'b1, "R5", "write beats ack");
    sw_wr[0] = 1'b0; sw_wdata[0] = 1'b0; irq_ack[0] = 1'b0;
    tick(2); chk(pend[0], 1'b1, "R5", "held after write");
    sw_wr[0] = 1'b1; tick(1); sw_wr[0] = 1'b0;
    chk(pend[0], 1'b0, "R5", "cleared for next test");
  endtask

  task automatic t_edge_vs_ack;
    ext_n[0] = 1'b1; tick(4);
    sw_wr[0] = 1'b1; sw_wdata[0] = 1'b1; tick(1); sw_wr[0] = 1'b0;
    ext_n[0] = 1'b0; tick(2);
    irq_ack[0] = 1'b1; tick(1); irq_ack[0] = 1'b0;
    chk(pend[0], 1'b1, "R6", "edge with ack keeps flag");
    irq_ack[0] = 1'b1; tick(1); irq_ack[0] = 1'b0;
    chk(pend[0], 1'b0, "R4", "ack without edge clears");
    ext_n[0] = 1'b1; tick(4);
    ext_n[0] = 1'b0; tick(2);
    sw_wr[0] = 1'b1; sw_wdata[0] = 1'b0; tick(1); sw_wr[0] = 1'b0;
    chk(pend[0], 1'b1, "R6", "edge with write 0 keeps flag");
    sw_wr[0] = 1'b1; tick(1); sw_wr[0] = 1'b0;
    chk(pend[0], 1'b0, "R5", "write 0 clears after edge");
  endtask

  task automatic t_mode_switch;
    sense_sel[0] = 1'b0; tick(1);
    chk(pend[0], 1'b0, "R9", "mode not yet applied");
    tick(1); chk(pend[0], 1'b1, "R9", "level follows low pin");
  endtask

  task automatic t_level;
    sw_wr[0] = 1'b1; sw_wdata[0] = 1'b0; irq_ack[0] = 1'b1; tick(1);
    chk(pend[0], 1'b1, "R8", "write 0 and ack ignored");
    sw_wr[0] = 1'b0; irq_ack[0] = 1'b0;
    ext_n[0] = 1'b1; tick(2);
    chk(pend[0], 1'b1, "R7", "pend before 3rd edge");
    tick(1); chk(pend[0], 1'b0, "R7", "pin high clears");
    sw_wr[0] = 1'b1; sw_wdata[0] = 1'b1; tick(1); sw_wr[0] = 1'b0;
    chk(pend[0], 1'b0, "R8", "write 1 ignored");
    ext_n[1] = 1'b0; tick(3);
    chk(pend[1], 1'b1, "R3", "line1 edge sets");
    chk(pend[0], 1'b0, "R10", "line0 unaffected by line1");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(1);
    t_reset();
    t_edge_set_ack();
    t_sw_write();
    t_edge_vs_ack();
    t_mode_switch();
    t_level();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule